// File: doc/BRIEF.md
# Interrupt and Reset Sequencer

This block is the control logic that takes a small 8-bit CPU out of its normal instruction flow. Four causes can do so: a reset, a non-maskable interrupt, a maskable interrupt and a software break. The block watches the active-low reset, NMI and IRQ pins, the interrupt-disable flag and two strobes from the instruction decoder. The first strobe marks an instruction boundary. The second marks that the instruction ending at that boundary is a break opcode. When a cause wins, the block requests entry into a fixed seven-cycle service sequence.

Each sequence has the same shape. It starts with two internal cycles. Three stack cycles follow, which push the PC high byte, the PC low byte and the status byte. It ends with two vector read cycles. A reset sequence keeps the seven-cycle shape but writes nothing to the stack. During the sequence the block drives the chosen vector address and the stack write strobe with a byte selector. It also drives an active-low vector-pull flag and a one-cycle strobe that sets the interrupt-disable flag. The decoder and the stack memory around it are out of scope.

NMI is edge-latched. IRQ is level-sensitive and masked by the flag. Reset wins over everything else and does not wait for an instruction boundary.

Top module: `intr_seq`

## Requirements
- R1: While `resN` is low, every output is idle: `serviceReq`=0, `vecPullN`=1, `stackWr`=0, `setIStb`=0, `vecAddr`=0, `pushSel`=0.
- R2: In the first cycle that `resN` is high after being low, `serviceReq` is 1 whatever the other inputs. A seven-cycle reset sequence follows with no stack write, and its vector reads use 16'hFFFC and then 16'hFFFD.
- R3: A falling edge on `nmiN` is latched. At the next cycle with `instrDone`=1 and no sequence running, an NMI sequence starts, with vector reads at 16'hFFFA and then 16'hFFFB.
- R4: Holding `nmiN` low after its edge produces no further NMI sequence, however many boundaries follow.
- R5: The pending NMI is cleared in the cycle its low vector byte is read. A falling edge sampled from that cycle onward, or at any point during a non-NMI sequence, produces one more NMI sequence.
- R6: When `irqN`=0 at a boundary, an IRQ sequence starts only if `iFlag`=0, and it reads the vector at 16'hFFFE and then 16'hFFFF. With `iFlag`=1 the request is ignored.
- R7: `brkOp`=1 together with `instrDone`=1 starts a break sequence. It uses the 16'hFFFE/16'hFFFF vector and performs the three stack pushes.
- R8: `serviceReq` is combinational and lasts one cycle. Causes are ranked reset, then NMI, then IRQ, then break. The sequence starts in the cycle after `serviceReq`.
- R9: In non-reset sequences, cycles 2, 3 and 4 after the start (counting the first sequence cycle as 0) assert `stackWr`. In those cycles `pushSel` is 0 (PC high), then 1 (PC low), then 2 (status). `pushSel` is 0 whenever `stackWr` is 0.
- R10: `vecPullN` is low only in sequence cycles 5 and 6. `vecAddr` holds the even vector base through the whole sequence, has bit 0 set in cycle 6, and is 0 outside a sequence.
- R11: `setIStb` is high for exactly one cycle per sequence, in cycle 5, the read of the low vector byte.
- R12: While a sequence runs, `instrDone`, `brkOp` and `irqN` start nothing; `serviceReq` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| resN | input | 1 | Active-low reset pin, sampled on the clock |
| nmiN | input | 1 | Active-low non-maskable interrupt pin (edge) |
| irqN | input | 1 | Active-low maskable interrupt pin (level) |
| iFlag | input | 1 | Interrupt-disable flag from the status register |
| instrDone | input | 1 | Instruction boundary strobe |
| brkOp | input | 1 | Instruction ending at this boundary is a break |
| serviceReq | output | 1 | Request to enter the service sequence |
| vecAddr | output | 16 | Selected vector address, 0 when idle |
| vecPullN | output | 1 | Low during the two vector read cycles |
| setIStb | output | 1 | One-cycle strobe that sets the interrupt-disable flag |
| stackWr | output | 1 | Stack write strobe |
| pushSel | output | 2 | Byte pushed: 0 PC high, 1 PC low, 2 status |

## Verification
Directed patterns come first. One is a held reset and its release. One is a single NMI edge, and another is an NMI held low across many boundaries; together they separate edge from level detection. An NMI edge placed just before and just after the vector fetch checks the clear point. Masked and unmasked IRQ levels check the flag gating. A break opcode alone and a boundary with every cause present at once check the priority order and the shared vector. After these, a long constrained-random run drives all pins with a fixed seed, including resets in mid-sequence, and compares every output on every cycle with a cycle model built from the requirements. That run exposes any off-by-one in push order, pull timing or NMI re-arming.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

  typedef enum logic [1:0] {
    SRC_RESET = 2'd0,
    SRC_NMI   = 2'd1,
    SRC_IRQ   = 2'd2,
    SRC_BRK   = 2'd3
  } svc_src_e;

  // Strobes from the sequence control to the datapath
  typedef struct packed {
    logic       active;   // a service sequence is running
    logic       pushEn;   // stack write cycle
    logic [1:0] pushIdx;  // 0 PC high, 1 PC low, 2 status
    logic       pullLo;   // low vector byte read
    logic       pullHi;   // high vector byte read
    logic       setI;     // set interrupt-disable flag
    logic       nmiAck;   // NMI vector fetch begins: drop the latch
    svc_src_e   src;      // cause being serviced
  } seq_ctrl_t;

endpackage

// File: rtl/intr_seq_ctrl.sv
module intr_seq_ctrl
  import intr_seq_pkg::*;
#(
  parameter int SEQ_LEN    = 7,
  parameter int PUSH_FIRST = 2,
  parameter int NUM_PUSH   = 3
) (
  input  logic      clk,
  input  logic      resN,
  input  logic      instrDone,
  input  logic      brkOp,
  input  logic      irqN,
  input  logic      iFlag,
  input  logic      nmiPend,
  output logic      serviceReq,
  output seq_ctrl_t ctrl
);

  localparam int STEP_W = $clog2(SEQ_LEN);
  localparam logic [STEP_W-1:0] LAST_STEP    = STEP_W'(SEQ_LEN - 1);
  localparam logic [STEP_W-1:0] PULL_LO_STEP = STEP_W'(SEQ_LEN - 2);
  localparam logic [STEP_W-1:0] PUSH_LO      = STEP_W'(PUSH_FIRST);
  localparam logic [STEP_W-1:0] PUSH_HI      = STEP_W'(PUSH_FIRST + NUM_PUSH - 1);

  logic              active;
  logic              resetPend;
  logic [STEP_W-1:0] step;
  svc_src_e          src;

  logic     irqLive;
  logic     startReset;
  logic     startOther;
  svc_src_e pickSrc;

  always_comb begin
    irqLive    = !irqN && !iFlag;
    startReset = resN && resetPend && !active;
    startOther = resN && !resetPend && !active && instrDone &&
                 (nmiPend || irqLive || brkOp);
    if (nmiPend)      pickSrc = SRC_NMI;
    else if (irqLive) pickSrc = SRC_IRQ;
    else              pickSrc = SRC_BRK;
  end

  assign serviceReq = startReset || startOther;

  always_ff @(posedge clk) begin
    if (!resN) begin
      resetPend <= 1'b1;
      active    <= 1'b0;
      step      <= '0;
      src       <= SRC_RESET;
    end else if (active) begin
      if (step == LAST_STEP) begin
        active <= 1'b0;
        step   <= '0;
      end else begin
        step <= step + STEP_W'(1);
      end
    end else if (startReset) begin
      active    <= 1'b1;
      step      <= '0;
      src       <= SRC_RESET;
      resetPend <= 1'b0;
    end else if (startOther) begin
      active <= 1'b1;
      step   <= '0;
      src    <= pickSrc;
    end
  end

  always_comb begin
    ctrl         = '0;
    ctrl.active  = active;
    ctrl.src     = src;
    ctrl.pushEn  = active && (src != SRC_RESET) &&
                   (step >= PUSH_LO) && (step <= PUSH_HI);
    ctrl.pushIdx = ctrl.pushEn ? 2'(step - PUSH_LO) : 2'd0;
    ctrl.pullLo  = active && (step == PULL_LO_STEP);
    ctrl.pullHi  = active && (step == LAST_STEP);
    ctrl.setI    = ctrl.pullLo;
    ctrl.nmiAck  = ctrl.pullLo && (src == SRC_NMI);
  end

  // R8: a request lasts a single cycle
  p_req_single_r8: assert property (@(posedge clk) disable iff (!resN)
    serviceReq |=> !serviceReq);

  // R12: no request while a sequence runs
  p_no_req_busy_r12: assert property (@(posedge clk) disable iff (!resN)
    (active && $past(active)) |-> !serviceReq);

  // R9: the PC high push is followed by the PC low push
  p_push_order_r9: assert property (@(posedge clk) disable iff (!resN)
    (ctrl.pushEn && ctrl.pushIdx == 2'd0) |=> (ctrl.pushEn && ctrl.pushIdx == 2'd1));

endmodule

// File: rtl/intr_seq_dpath.sv
module intr_seq_dpath
  import intr_seq_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] VEC_NMI   = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_RESET = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_IRQ   = 16'hFFFE
) (
  input  logic              clk,
  input  logic              resN,
  input  logic              nmiN,
  input  seq_ctrl_t         ctrl,
  output logic              nmiPend,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              vecPullN,
  output logic              setIStb,
  output logic              stackWr,
  output logic [1:0]        pushSel
);

  logic              nmiPrev;
  logic              nmiFall;
  logic [ADDR_W-1:0] vecBase;

  assign nmiFall = nmiPrev && !nmiN;

  // Pin history follows the pin even in reset, so a pin held low
  // across reset is not taken as an edge
  always_ff @(posedge clk) begin
    nmiPrev <= nmiN;
    if (!resN)        nmiPend <= 1'b0;
    else if (nmiFall) nmiPend <= 1'b1;
    else if (ctrl.nmiAck) nmiPend <= 1'b0;
  end

  always_comb begin
    case (ctrl.src)
      SRC_RESET: vecBase = VEC_RESET;
      SRC_NMI:   vecBase = VEC_NMI;
      default:   vecBase = VEC_IRQ;
    endcase
  end

  assign vecAddr  = (resN && ctrl.active) ? (vecBase | ADDR_W'(ctrl.pullHi)) : '0;
  assign vecPullN = !(resN && (ctrl.pullLo || ctrl.pullHi));
  assign setIStb  = resN && ctrl.setI;
  assign stackWr  = resN && ctrl.pushEn;
  assign pushSel  = (resN && ctrl.pushEn) ? ctrl.pushIdx : 2'd0;

  // R3: a falling edge on the pin leaves an NMI pending
  p_nmi_latch_r3: assert property (@(posedge clk) disable iff (!resN)
    (!nmiN && $past(nmiN)) |=> nmiPend);

  // R10: low byte read (even address) is followed by high byte read
  p_pull_pair_r10: assert property (@(posedge clk) disable iff (!resN)
    (!vecPullN && !vecAddr[0]) |=> (!vecPullN && vecAddr[0]));

  // R10: the pull flag returns high after the high byte
  p_pull_end_r10: assert property (@(posedge clk) disable iff (!resN)
    (!vecPullN && vecAddr[0]) |=> vecPullN);

  // R11: I is set during the low vector byte read
  p_seti_lo_r11: assert property (@(posedge clk) disable iff (!resN)
    setIStb |-> (!vecPullN && !vecAddr[0]));

  // R2: a reset sequence writes nothing to the stack
  p_no_push_reset_r2: assert property (@(posedge clk) disable iff (!resN)
    stackWr |-> (vecAddr != VEC_RESET));

endmodule

// File: rtl/intr_seq.sv
module intr_seq
  import intr_seq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SEQ_LEN = 7
) (
  input  logic              clk,
  input  logic              resN,
  input  logic              nmiN,
  input  logic              irqN,
  input  logic              iFlag,
  input  logic              instrDone,
  input  logic              brkOp,
  output logic              serviceReq,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              vecPullN,
  output logic              setIStb,
  output logic              stackWr,
  output logic [1:0]        pushSel
);

  seq_ctrl_t ctrl;
  logic      nmiPend;

  intr_seq_ctrl #(
    .SEQ_LEN   (SEQ_LEN),
    .PUSH_FIRST(2),
    .NUM_PUSH  (3)
  ) u_ctrl (
    .clk       (clk),
    .resN      (resN),
    .instrDone (instrDone),
    .brkOp     (brkOp),
    .irqN      (irqN),
    .iFlag     (iFlag),
    .nmiPend   (nmiPend),
    .serviceReq(serviceReq),
    .ctrl      (ctrl)
  );

  intr_seq_dpath #(
    .ADDR_W   (ADDR_W),
    .VEC_NMI  (ADDR_W'(16'hFFFA)),
    .VEC_RESET(ADDR_W'(16'hFFFC)),
    .VEC_IRQ  (ADDR_W'(16'hFFFE))
  ) u_dpath (
    .clk     (clk),
    .resN    (resN),
    .nmiN    (nmiN),
    .ctrl    (ctrl),
    .nmiPend (nmiPend),
    .vecAddr (vecAddr),
    .vecPullN(vecPullN),
    .setIStb (setIStb),
    .stackWr (stackWr),
    .pushSel (pushSel)
  );

endmodule

// File: tb/intr_seq_tb.sv
`timescale 1ns/1ps
module intr_seq_tb;

  logic        clk = 1'b0;
  logic        resN = 1'b0, nmiN = 1'b1, irqN = 1'b1, iFlag = 1'b1;
  logic        instrDone = 1'b0, brkOp = 1'b0;
  logic        serviceReq, vecPullN, setIStb, stackWr;
  logic [15:0] vecAddr;
  logic [1:0]  pushSel;

  always #5 clk = ~clk;

  intr_seq u_dut (
    .clk(clk), .resN(resN), .nmiN(nmiN), .irqN(irqN), .iFlag(iFlag),
    .instrDone(instrDone), .brkOp(brkOp), .serviceReq(serviceReq),
    .vecAddr(vecAddr), .vecPullN(vecPullN), .setIStb(setIStb),
    .stackWr(stackWr), .pushSel(pushSel)
  );

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // Reference cycle model (from the requirements)
  bit mResPend = 1, mInSeq = 0, mNmiPend = 0, mNmiPrev = 1;
  int mStep = 0, mKind = 0; // 0 reset, 1 nmi, 2 irq, 3 brk

  // Observed event counters
  int nNmi = 0, nRes = 0, nIrq = 0, nReq = 0, nWr = 0;

  logic        eReq, ePullN, eSetI, eWr;
  logic [15:0] eVec;
  logic [1:0]  eSel;

  function automatic logic [15:0] vecBaseOf(int kind);
    if (kind == 0) return 16'hFFFC;
    if (kind == 1) return 16'hFFFA;
    return 16'hFFFE;
  endfunction

  function automatic bit startOtherNow();
    return !mInSeq && !mResPend && instrDone &&
           (mNmiPend || (!irqN && !iFlag) || brkOp);
  endfunction

  task automatic computeExpect();
    eReq = 0; ePullN = 1; eSetI = 0; eWr = 0; eVec = 16'h0; eSel = 2'd0;
    if (resN) begin
      eReq = (mResPend && !mInSeq) || startOtherNow();
      if (mInSeq) begin
        eWr    = (mKind != 0) && mStep >= 2 && mStep <= 4;
        eSel   = eWr ? 2'(mStep - 2) : 2'd0;
        ePullN = !(mStep >= 5);
        eSetI  = (mStep == 5);
        eVec   = vecBaseOf(mKind) | ((mStep == 6) ? 16'h1 : 16'h0);
      end
    end
  endtask

  task automatic updateModel();
    bit fall, clr, sr, so, irqLive;
    fall = mNmiPrev && !nmiN;
    if (!resN) begin
      mResPend = 1; mInSeq = 0; mStep = 0; mNmiPend = 0;
    end else begin
      irqLive = !irqN && !iFlag;
      clr = mInSeq && mKind == 1 && mStep == 5;
      sr  = mResPend && !mInSeq;
      so  = startOtherNow();
      if (mInSeq) begin
        if (mStep == 6) begin mInSeq = 0; mStep = 0; end
        else mStep++;
      end else if (sr) begin
        mInSeq = 1; mStep = 0; mKind = 0; mResPend = 0;
      end else if (so) begin
        mInSeq = 1; mStep = 0;
        mKind = mNmiPend ? 1 : (irqLive ? 2 : 3);
      end
      if (fall) mNmiPend = 1;
      else if (clr) mNmiPend = 0;
    end
    mNmiPrev = nmiN;
  endtask

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // One clock: inputs are already set at the falling edge
  task automatic tick();
    string t;
    #4;
    computeExpect();
    t = resN ? "" : "R1";
    check(resN ? "R8"  : t, "serviceReq", 16'(serviceReq), 16'(eReq));
    check(resN ? "R10" : t, "vecAddr",    vecAddr,         eVec);
    check(resN ? "R10" : t, "vecPullN",   16'(vecPullN),   16'(ePullN));
    check(resN ? "R9"  : t, "stackWr",    16'(stackWr),    16'(eWr));
    check(resN ? "R9"  : t, "pushSel",    16'(pushSel),    16'(eSel));
    check(resN ? "R11" : t, "setIStb",    16'(setIStb),    16'(eSetI));
    if (serviceReq === 1'b1) nReq++;
    if (stackWr === 1'b1) nWr++;
    if (vecPullN === 1'b0) begin
      if (vecAddr == 16'hFFFA) nNmi++;
      if (vecAddr == 16'hFFFC) nRes++;
      if (vecAddr == 16'hFFFE) nIrq++;
    end
    @(posedge clk);
    updateModel();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic boundary();
    instrDone = 1; tick(); instrDone = 0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int b0, b1, b2, b3, b4;
    void'($urandom(32'h1F2E3D4C));
    @(negedge clk);

    // R1: held reset, outputs idle
    instrDone = 1; brkOp = 1;
    idle(3);
    instrDone = 0; brkOp = 0;

    // R2: release, reset sequence without pushes, vector FFFC
    b0 = nRes; b1 = nWr; b2 = nReq;
    resN = 1;
    idle(9);
    check("R2", "reset vector reads", 16'(nRes - b0), 16'd1);
    check("R2", "reset stack writes", 16'(nWr - b1), 16'd0);
    check("R2", "reset requests", 16'(nReq - b2), 16'd1);

    // R3: single NMI edge, serviced at the boundary
    iFlag = 1;
    b0 = nNmi;
    nmiN = 0; tick(); nmiN = 1; idle(3);
    check("R3", "no service before boundary", 16'(nNmi - b0), 16'd0);
    boundary(); idle(8);
    check("R3", "nmi vector reads", 16'(nNmi - b0), 16'd1);

    // R4: NMI held low across many boundaries
    b0 = nNmi;
    nmiN = 0;
    for (int k = 0; k < 6; k++) begin boundary(); idle(8); end
    check("R4", "nmi held low services", 16'(nNmi - b0), 16'd1);
    nmiN = 1; idle(2);

    // R5: edge after the vector fetch starts re-triggers
    b0 = nNmi;
    nmiN = 0; tick(); nmiN = 1; tick();
    boundary();          // request
    idle(6);             // steps 0..5
    nmiN = 0; tick();    // step 6: new edge
    nmiN = 1; idle(2);
    boundary(); idle(8);
    check("R5", "nmi retrigger services", 16'(nNmi - b0), 16'd2);

    // R5: NMI edge during an IRQ sequence is kept
    b0 = nNmi; b1 = nIrq;
    irqN = 0; iFlag = 0;
    boundary();
    irqN = 1; iFlag = 1;
    idle(2); nmiN = 0; tick(); nmiN = 1; idle(5);
    boundary(); idle(8);
    check("R5", "irq then nmi: irq", 16'(nIrq - b1), 16'd1);
    check("R5", "irq then nmi: nmi", 16'(nNmi - b0), 16'd1);

    // R6: masked IRQ ignored, unmasked IRQ serviced
    b1 = nIrq; b2 = nReq;
    irqN = 0; iFlag = 1;
    for (int k = 0; k < 4; k++) boundary();
    check("R6", "masked irq requests", 16'(nReq - b2), 16'd0);
    iFlag = 0; boundary(); irqN = 1; idle(8);
    check("R6", "unmasked irq vector reads", 16'(nIrq - b1), 16'd1);
    iFlag = 1;

    // R7: break opcode at a boundary
    b1 = nIrq; b3 = nWr;
    brkOp = 1; boundary(); brkOp = 0; idle(8);
    check("R7", "break vector reads", 16'(nIrq - b1), 16'd1);
    check("R7", "break stack writes", 16'(nWr - b3), 16'd3);

    // R8: NMI beats IRQ and break at the same boundary
    b0 = nNmi; b1 = nIrq;
    nmiN = 0; tick(); nmiN = 1;
    irqN = 0; iFlag = 0; brkOp = 1; boundary();
    irqN = 1; iFlag = 1; brkOp = 0; idle(8);
    check("R8", "priority nmi taken", 16'(nNmi - b0), 16'd1);
    check("R8", "priority irq deferred", 16'(nIrq - b1), 16'd0);

    // R8: reset beats a boundary with every cause present
    b0 = nNmi; b4 = nRes;
    resN = 0; idle(2);
    resN = 1; irqN = 0; iFlag = 0; brkOp = 1; instrDone = 1;
    tick();
    irqN = 1; iFlag = 1; brkOp = 0; instrDone = 0;
    idle(8);
    check("R8", "reset first", 16'(nRes - b4), 16'd1);

    // R12: strobes during a sequence start nothing
    b2 = nReq;
    brkOp = 1; boundary();
    for (int k = 0; k < 7; k++) begin irqN = 0; iFlag = 0; boundary(); end
    irqN = 1; iFlag = 1; brkOp = 0;
    idle(4);
    check("R12", "requests across busy window", 16'(nReq - b2), 16'd1);

    // Constrained random run, compared every cycle
    for (int c = 0; c < 6000; c++) begin
      if (!resN) resN = ($urandom_range(0, 2) != 0);
      else if ($urandom_range(0, 299) == 0) resN = 0;
      if ($urandom_range(0, 14) == 0) nmiN = ~nmiN;
      if ($urandom_range(0, 9) == 0) irqN = ~irqN;
      if ($urandom_range(0, 19) == 0) iFlag = ~iFlag;
      instrDone = ($urandom_range(0, 2) == 0);
      brkOp = instrDone && ($urandom_range(0, 7) == 0);
      tick();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule